// File: doc/BRIEF.md
# Level-Triggered DMA Block Request Sequencer

This block sequences one DMA channel that moves data in blocks, started by an active-low, level-sensitive request pin. A configuration write strobe arms the channel with a block size and a block count. From the clock edge after that write, the request pin is sampled on every edge while the acceptance window is open. A low level latches a pending request and closes the window. The sequencer then asks for the bus and waits for the grant. On the grant it clears the pending request and issues one block of read/write cycle pairs while it holds the bus.

After the last write of a block, the sequencer inserts one dead cycle and then one cycle in which it releases the bus. The acceptance window reopens on the cycle after that. The request pin has no effect from the moment a request is latched until the window reopens. The loop runs once per block. After the programmed number of blocks the channel disables itself, pulses a done flag for one cycle and ignores the pin until it is armed again.

Top module: `dma_blk_seq`

## Requirements
- R1: A `cfg_wr` pulse with a nonzero `cfg_blocks` while the channel is idle sets `chan_en` and `acc_open` in the next cycle. The pin level present during the write cycle itself is never latched, and sampling starts at the first clock edge after the write.
- R2: If `dreq_n` is sampled low while `acc_open` is 1, then in the next cycle `req_held`=1, `bus_req`=1 and `acc_open`=0.
- R3: If `dreq_n` is sampled high while the window is open, no request is made: `req_held` and `bus_req` stay 0, `acc_open` stays 1, and sampling continues on the next edge.
- R4: While waiting for the grant, `req_held` stays 1 and `dreq_n` has no effect. At the first edge with `bus_grant`=1, the held request clears and `rd_stb` is 1 in the next cycle.
- R5: A block is `cfg_size_m1`+1 transfer pairs (`cfg_size_m1` is 8 bits, so 1 to 256 pairs). Each pair is one cycle with `rd_stb`=1 followed by one cycle with `wr_stb`=1, and the pairs follow each other with no gap.
- R6: `bus_req` stays 1 from the cycle after the request is latched through the dead cycle.
- R7: After the last write of a block there is exactly one cycle with `dead`=1, then one release cycle with `bus_req`=0, and then `acc_open` returns to 1. From the clearing of the request until the window reopens, `dreq_n` has no effect, and that span lasts at least 2 cycles.
- R8: After `cfg_blocks` blocks, the release cycle is followed by a cycle with `done`=1 (high for one cycle only) and `chan_en`=0. While idle, `dreq_n` is ignored.
- R9: `cfg_wr` has no effect while `chan_en` is 1, and a `cfg_wr` with `cfg_blocks`=0 leaves the channel disabled.
- R10: During and after reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe that arms the channel |
| cfg_size_m1 | input | 8 | Block size minus one, in transfer pairs |
| cfg_blocks | input | CNT_W | Number of blocks to transfer |
| dreq_n | input | 1 | Active-low level request pin |
| bus_grant | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request, held for a whole block |
| rd_stb | output | 1 | Source read cycle strobe |
| wr_stb | output | 1 | Destination write cycle strobe |
| dead | output | 1 | Dead cycle after a block |
| acc_open | output | 1 | Request acceptance window open |
| req_held | output | 1 | Request latched and pending activation |
| chan_en | output | 1 | Channel enabled |
| done | output | 1 | One-cycle pulse when the last block completes |

## Verification
The hardest case to reach from the ports is a request level that stays low while acceptance is closed: during the grant wait, across the read/write pairs, the dead cycle and the release cycle, and in the cycle of the enabling write. A level-sensitive pin can cause extra blocks in any of these places. The bench holds `dreq_n` low or toggles it at random through every one of those cycles. It also stretches the grant delay and the open-window wait with seeded random lengths, and it counts read strobes against the exact total of blocks times pairs. Directed runs cover block sizes of 1 and 256, a write made while the pin is already low, a new configuration written mid-transfer, and a write with a zero block count.

// File: rtl/dma_blk_pkg.sv
// Shared types for the block request sequencer.
package dma_blk_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ACCEPT  = 3'd1,
        ST_WAITBUS = 3'd2,
        ST_RD      = 3'd3,
        ST_WR      = 3'd4,
        ST_DEAD    = 3'd5,
        ST_REL     = 3'd6
    } seq_state_t;
endpackage

// File: rtl/dma_req_sampler.sv
// Request sampler: while the window is open, a low pin level is taken as a
// request and held until activation clears it.
// Assumes: window is low whenever acceptance is closed.
module dma_req_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic window,
    input  logic dreq_n,
    input  logic activate,
    output logic take,
    output logic held
);
    // take: a request is seen in this cycle
    always_comb take = window & ~dreq_n;

    // held: set on take, cleared at activation
    always_ff @(posedge clk) begin
        if (!rst_n)        held <= 1'b0;
        else if (activate) held <= 1'b0;
        else if (take)     held <= 1'b1;
    end
endmodule

// File: rtl/dma_xfer_ctr.sv
// Transfer pair counter inside a block. Stores the block size (minus one)
// at arming and flags the last pair.
// Assumes: load and step are never high together.
module dma_xfer_ctr #(
    parameter int SIZE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] size_m1_in,
    input  logic              clr,
    input  logic              step,
    output logic              last
);
    logic [SIZE_W-1:0] size_q;
    logic [SIZE_W-1:0] cnt_q;

    // size_q: block size captured when the channel is armed
    always_ff @(posedge clk) begin
        if (!rst_n)    size_q <= '0;
        else if (load) size_q <= size_m1_in;
    end

    // cnt_q: pair index inside the current block
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (clr)  cnt_q <= '0;
        else if (step) cnt_q <= cnt_q + 1'b1;
    end

    // last: the current pair closes the block
    always_comb last = (cnt_q == size_q);
endmodule

// File: rtl/dma_blk_ctr.sv
// Block counter: loaded with the number of blocks, counts one down per
// block and flags the final block.
// Assumes: a load value of zero is filtered out upstream.
module dma_blk_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] blocks_in,
    input  logic             dec,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // cnt_q: blocks still to run, including the current one
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= blocks_in;
        else if (dec)  cnt_q <= cnt_q - ONE;
    end

    // last: this is the final block
    always_comb last = (cnt_q == ONE);
endmodule

// File: rtl/dma_blk_seq.sv
// Level-triggered DMA block request sequencer for a single channel.
// Flow: arm, open acceptance, latch a request, request the bus, clear the
// request at the grant, run the read/write pairs, one dead cycle, one release
// cycle, then reopen acceptance or finish.
// Assumes: once bus_grant is given, it stays until bus_req drops.
module dma_blk_seq
    import dma_blk_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [SIZE_W-1:0] cfg_size_m1,
    input  logic [CNT_W-1:0]  cfg_blocks,
    input  logic              dreq_n,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              dead,
    output logic              acc_open,
    output logic              req_held,
    output logic              chan_en,
    output logic              done
);
    seq_state_t state_q, state_d;
    logic cfg_take, take, activate, xfer_last, blk_last, done_q;

    // cfg_take: an arming write is accepted only while idle with blocks > 0
    always_comb cfg_take = cfg_wr && (state_q == ST_IDLE) && (cfg_blocks != '0);

    // activate: the grant arrives while a request is held
    always_comb activate = (state_q == ST_WAITBUS) && bus_grant;

    dma_req_sampler u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .window   (state_q == ST_ACCEPT),
        .dreq_n   (dreq_n),
        .activate (activate),
        .take     (take),
        .held     (req_held)
    );

    dma_xfer_ctr #(.SIZE_W(SIZE_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_take),
        .size_m1_in (cfg_size_m1),
        .clr        (activate),
        .step       ((state_q == ST_WR) && !xfer_last),
        .last       (xfer_last)
    );

    dma_blk_ctr #(.CNT_W(CNT_W)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_take),
        .blocks_in (cfg_blocks),
        .dec       (state_q == ST_REL),
        .last      (blk_last)
    );

    // state_d: next-state choice of the sequence
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (cfg_take) state_d = ST_ACCEPT;
            ST_ACCEPT:  if (take)     state_d = ST_WAITBUS;
            ST_WAITBUS: if (activate) state_d = ST_RD;
            ST_RD:                    state_d = ST_WR;
            ST_WR:                    state_d = xfer_last ? ST_DEAD : ST_RD;
            ST_DEAD:                  state_d = ST_REL;
            ST_REL:                   state_d = blk_last ? ST_IDLE : ST_ACCEPT;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state_q: sequence state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // done_q: pulse for one cycle after the final release cycle
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (state_q == ST_REL) && blk_last;
    end

    // outputs decoded from the state
    always_comb begin
        bus_req  = (state_q == ST_WAITBUS) || (state_q == ST_RD) ||
                   (state_q == ST_WR) || (state_q == ST_DEAD);
        rd_stb   = (state_q == ST_RD);
        wr_stb   = (state_q == ST_WR);
        dead     = (state_q == ST_DEAD);
        acc_open = (state_q == ST_ACCEPT);
        chan_en  = (state_q != ST_IDLE);
        done     = done_q;
    end
endmodule

// File: rtl/dma_blk_seq_chk.sv
// Property checker for dma_blk_seq, attached with bind.
module dma_blk_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic dreq_n,
    input logic bus_req,
    input logic rd_stb,
    input logic wr_stb,
    input logic dead,
    input logic acc_open,
    input logic req_held,
    input logic chan_en,
    input logic done
);
    // R2: a held request comes only from a low sample in an open window
    a_r2_latch_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_held) |-> ($past(acc_open) && !$past(dreq_n)));

    // R2: a low sample in the open window closes it and requests the bus
    a_r2_take: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_open && !dreq_n) |=> (req_held && bus_req && !acc_open));

    // R4: the held request clears only as the first read begins
    a_r4_clear_at_read: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_held) |-> rd_stb);

    // R5: each read is followed by a write
    a_r5_rd_then_wr: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> wr_stb);

    // R6: the bus is held during transfers and the dead cycle
    a_r6_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb || dead) |-> bus_req);

    // R7: acceptance stays closed from activation through the dead cycle
    a_r7_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb || wr_stb || dead) |-> (!acc_open && !req_held));

    // R7: the dead cycle is followed by a release cycle
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> (!bus_req && !acc_open && !dead));

    // R8: done comes with the channel disabled, for one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!chan_en && !bus_req) ##1 !done);

    // R8: nothing runs while the channel is disabled
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> (!bus_req && !req_held && !acc_open));

    // R5: phase outputs are mutually exclusive
    a_r5_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_stb, wr_stb, dead, acc_open}));
endmodule

bind dma_blk_seq dma_blk_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dreq_n   (dreq_n),
    .bus_req  (bus_req),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .dead     (dead),
    .acc_open (acc_open),
    .req_held (req_held),
    .chan_en  (chan_en),
    .done     (done)
);

// File: tb/dma_blk_seq_tb.sv
`timescale 1ns/1ps
module dma_blk_seq_tb;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0;
    logic [7:0] cfg_size_m1 = '0;
    logic [CNT_W-1:0] cfg_blocks = '0;
    logic dreq_n = 1'b1;
    logic bus_grant = 1'b0;
    logic bus_req, rd_stb, wr_stb, dead, acc_open, req_held, chan_en, done;

    int n_chk = 0;
    int n_bad = 0;
    int n_rd = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dma_blk_seq #(.SIZE_W(8), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_size_m1(cfg_size_m1),
        .cfg_blocks(cfg_blocks), .dreq_n(dreq_n), .bus_grant(bus_grant),
        .bus_req(bus_req), .rd_stb(rd_stb), .wr_stb(wr_stb), .dead(dead),
        .acc_open(acc_open), .req_held(req_held), .chan_en(chan_en), .done(done)
    );

    // count read strobes seen between edges
    always @(negedge clk) if (rd_stb) n_rd++;

    function automatic int exp_reads(input int sz_m1, input int nblk);
        return (sz_m1 + 1) * nblk;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    // one full armed run of nblk blocks of sz_m1+1 pairs
    task automatic run_xfer(input int sz_m1, input int nblk, input bit early, input bit rewrite);
        int rd0;
        rd0 = n_rd;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_size_m1 = 8'(sz_m1); cfg_blocks = CNT_W'(nblk);
        dreq_n = early ? 1'b0 : 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; dreq_n = 1'b1;
        check("R1 chan_en after write", int'(chan_en), 1);
        check("R1 acc_open after write", int'(acc_open), 1);
        @(negedge clk);
        check("R1 write-cycle level not latched", int'(req_held), 0);
        for (int b = 0; b < nblk; b++) begin
            for (int d = 0; d < int'($urandom_range(0, 3)); d++) begin
                @(negedge clk);
                check("R3 high level no request", int'(req_held | bus_req), 0);
                check("R3 window stays open", int'(acc_open), 1);
            end
            dreq_n = 1'b0;
            if (rewrite) begin
                cfg_wr = 1'b1; cfg_size_m1 = 8'd0; cfg_blocks = CNT_W'(1);
            end
            @(negedge clk);
            cfg_wr = 1'b0; dreq_n = 1'($urandom_range(0, 1));
            check("R2 request held", int'(req_held), 1);
            check("R2 bus requested", int'(bus_req), 1);
            check("R2 window closed", int'(acc_open), 0);
            for (int g = 0; g < int'($urandom_range(0, 3)); g++) begin
                dreq_n = 1'($urandom_range(0, 1));
                @(negedge clk);
                check("R4 held while waiting", int'(req_held), 1);
                check("R4 no read before grant", int'(rd_stb), 0);
            end
            bus_grant = 1'b1; dreq_n = 1'b0;
            @(negedge clk);
            check("R4 read after grant", int'(rd_stb), 1);
            check("R4 request cleared", int'(req_held), 0);
            for (int i = 0; i <= sz_m1; i++) begin
                check("R5 read phase", int'({rd_stb, wr_stb}), 2);
                check("R6 bus held in read", int'(bus_req), 1);
                @(negedge clk);
                check("R5 write phase", int'({rd_stb, wr_stb}), 1);
                check("R7 closed during block", int'(acc_open | req_held), 0);
                @(negedge clk);
            end
            check("R7 dead cycle", int'(dead), 1);
            check("R6 bus held in dead", int'(bus_req), 1);
            check("R7 no request in dead", int'(req_held | acc_open), 0);
            @(negedge clk);
            check("R7 release cycle bus", int'(bus_req), 0);
            check("R7 release cycle closed", int'(dead | acc_open | req_held), 0);
            bus_grant = 1'b0; dreq_n = 1'b1;
            @(negedge clk);
            if (b == nblk - 1) begin
                check("R8 done pulse", int'(done), 1);
                check("R8 channel off", int'(chan_en), 0);
                check("R8 window closed", int'(acc_open), 0);
            end else begin
                check("R7 acceptance reopened", int'(acc_open), 1);
                check("R8 no early done", int'(done), 0);
            end
        end
        dreq_n = 1'b0;
        @(negedge clk);
        check("R8 done one cycle", int'(done), 0);
        @(negedge clk);
        check("R8 pin ignored when idle", int'(req_held | bus_req | chan_en), 0);
        dreq_n = 1'b1;
        check("R5 total reads", n_rd - rd0, exp_reads(sz_m1, nblk));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R10 reset outputs", int'({bus_req, rd_stb, wr_stb, dead, acc_open, req_held, chan_en, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", int'({bus_req, acc_open, chan_en, done}), 0);
        // R9: zero block count does not arm
        cfg_wr = 1'b1; cfg_blocks = '0; cfg_size_m1 = 8'd3;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R9 zero blocks ignored", int'(chan_en | acc_open), 0);
        run_xfer(0, 1, 1'b0, 1'b0);
        run_xfer(255, 2, 1'b0, 1'b0);
        run_xfer(1, 3, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++)
            run_xfer(int'($urandom_range(0, 20)), int'($urandom_range(1, 4)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        summary();
    end
endmodule